// File: doc/BRIEF.md
# Byte-Mapped Serial Port Register File with Interrupt Identification

This block is the host-visible register side of a classic serial port. A host reaches eight byte-wide locations through a 3-bit address with separate read and write strobes. Behind them sit the transmit and receive data registers, the interrupt enable and identification registers, the line and modem control and status registers, a scratch byte, and a 16-bit divisor that can be stored and read back. Bit timing, baud generation, parity and FIFOs are not part of it. Transmitted bytes leave on a valid/ready byte stream. Received bytes and break events arrive on a byte port that is ready only while the receive buffer is empty.

One interrupt line is raised whenever the identification register shows a pending cause. Received data outranks an empty transmit holding register. The transmit cause is tracked by an internal pending flag. Reading the identification register while it names the transmit cause clears that flag, and rewriting the enable register while the holding register is empty sets it again. A loopback mode feeds the modem control outputs back into the modem status read value.

Top module: `uart_regfile`

## Requirements
- R1: After reset, line status (offset 5) reads 0x60, identification (offset 2) reads 0x01, irq is low, tx_valid is low and both divisor bytes read 0x00.
- R2: When line control bit 7 is set, offsets 0 and 1 write and read the low and high bytes of a 16-bit divisor instead of the data and enable registers, and nothing is sent on the transmit stream.
- R3: The enable register (offset 1) keeps only the low 4 bits written to it, and modem control (offset 4) keeps only the low 5 bits.
- R4: Identification reads 0x04 when data-ready and enable bit 0 are both set; otherwise 0x02 when the transmit-pending flag and enable bit 1 are both set; otherwise 0x01. irq is high exactly when the code is not 0x01.
- R5: A read of offset 2 that returns 0x02 clears the transmit-pending flag.
- R6: A write to the enable register while line status bit 5 (holding empty) is set sets the transmit-pending flag.
- R7: A write to offset 0 with line control bit 7 clear presents the byte on tx_data with tx_valid high, clears line status bits 5 and 6 and the pending flag, and holds tx_data steady until tx_ready; on acceptance bits 5 and 6 return to 1 and the pending flag is set.
- R8: A byte taken from the receive port is stored and sets line status bit 0 (data ready); rx_ready is low while bit 0 is set and bytes offered then are ignored.
- R9: A break event stores 0x00 in the receive buffer and sets line status bits 4 (break) and 0.
- R10: Reading offset 0 with line control bit 7 clear returns the receive buffer and clears line status bits 0 and 4.
- R11: With modem control bit 4 set, offset 6 reads control bits 3:2 on bits 7:6, control bit 0 on bit 5, control bit 1 on bit 4 and zero elsewhere; with bit 4 clear it reads the stored modem status byte.
- R12: Line control, modem status and scratch (offsets 3, 6, 7) read back what was written, and writes to offsets 2 and 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; read side effects take place at the clock edge |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit sink accepts the byte |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receive buffer empty, byte can be taken |
| rx_break | input | 1 | Break condition event |
| irq | output | 1 | Interrupt request |

## Verification
The identification logic is swept over all sixteen enable values, once with the receive buffer empty and once full. The empty pass separates the transmit cause from no cause. The full pass shows that received data outranks the transmit cause and that reading the 0x02 code clears the pending flag. The enable register is swept over all 256 write values to expose the masking. Modem control is swept over all 32 values to check both the loopback bit mapping and the pass-through of stored status. Transmit and receive are checked with a held-off sink, a refused second receive byte and a break, so that each line-status bit is seen to set and clear independently.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int unsigned AW    = 3;
  localparam int unsigned DW    = 8;
  localparam int unsigned DIV_W = 2 * DW;

  localparam logic [AW-1:0] OFS_DATA = 3'd0;
  localparam logic [AW-1:0] OFS_IEN  = 3'd1;
  localparam logic [AW-1:0] OFS_IID  = 3'd2;
  localparam logic [AW-1:0] OFS_LCTL = 3'd3;
  localparam logic [AW-1:0] OFS_MCTL = 3'd4;
  localparam logic [AW-1:0] OFS_LST  = 3'd5;
  localparam logic [AW-1:0] OFS_MST  = 3'd6;
  localparam logic [AW-1:0] OFS_SCR  = 3'd7;

  localparam logic [DW-1:0] IID_NONE = 8'h01;
  localparam logic [DW-1:0] IID_TXE  = 8'h02;
  localparam logic [DW-1:0] IID_RXD  = 8'h04;

  // Modem status value seen while the control outputs are looped back.
  function automatic logic [DW-1:0] loop_status(input logic [4:0] mctl);
    return {mctl[3:2], mctl[0], mctl[1], 4'b0000};
  endfunction

  // Prioritised identification code: receive data wins over transmit empty.
  function automatic logic [DW-1:0] iid_code(input logic rx_cause, input logic tx_cause);
    if (rx_cause)      return IID_RXD;
    else if (tx_cause) return IID_TXE;
    else               return IID_NONE;
  endfunction

  // Line status byte layout.
  function automatic logic [DW-1:0] lst_pack(input logic temt, input logic thre,
                                              input logic brk, input logic rdy);
    return {1'b0, temt, thre, brk, 3'b000, rdy};
  endfunction
endpackage

// File: rtl/uart_rf_ctl.sv
module uart_rf_ctl
  import uart_rf_pkg::*;
#(
  parameter int unsigned IEN_W  = 4,
  parameter int unsigned MCTL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic              dlab,
  output logic              ien_wr,
  output logic [DW-1:0]     lctl_q,
  output logic [IEN_W-1:0]  ien_q,
  output logic [MCTL_W-1:0] mctl_q,
  output logic [DW-1:0]     mst_q,
  output logic [DW-1:0]     scr_q,
  output logic [DIV_W-1:0]  div_q
);
  localparam int unsigned DIV_BYTES = DIV_W / DW;

  assign dlab   = lctl_q[DW-1];
  assign ien_wr = wr_en && (addr == OFS_IEN) && !dlab;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lctl_q <= '0;
      ien_q  <= '0;
      mctl_q <= '0;
      mst_q  <= '0;
      scr_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_IEN:  if (!dlab) ien_q <= wdata[IEN_W-1:0];
        OFS_LCTL: lctl_q <= wdata;
        OFS_MCTL: mctl_q <= wdata[MCTL_W-1:0];
        OFS_MST:  mst_q  <= wdata;
        OFS_SCR:  scr_q  <= wdata;
        default:  ;
      endcase
    end
  end

  // Divisor bytes, one per low offset while the latch access bit is set.
  for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div
    logic byte_wr;
    assign byte_wr = wr_en && dlab && (addr == AW'(b));
    always_ff @(posedge clk) begin
      if (!rst_n)       div_q[b*DW +: DW] <= '0;
      else if (byte_wr) div_q[b*DW +: DW] <= wdata;
    end
  end

  AST_DIV_NO_DATA_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dlab) |=> $stable(div_q)); // R2
endmodule

// File: rtl/uart_rf_line.sv
module uart_rf_line
  import uart_rf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_wr,
  input  logic [DW-1:0] thr_byte,
  input  logic          rbr_rd,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  input  logic          rx_break,
  output logic [DW-1:0] rbr_q,
  output logic [DW-1:0] lst,
  output logic          thre,
  output logic          rdy,
  output logic          tx_done
);
  logic temt_q, thre_q, brk_q, rdy_q;
  logic rx_take;

  assign tx_done  = tx_valid && tx_ready;
  assign rx_ready = !rdy_q;
  assign rx_take  = rx_valid && rx_ready;
  assign thre     = thre_q;
  assign rdy      = rdy_q;
  assign lst      = lst_pack(temt_q, thre_q, brk_q, rdy_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      thre_q   <= 1'b1;
      temt_q   <= 1'b1;
    end else if (thr_wr) begin
      tx_valid <= 1'b1;
      tx_data  <= thr_byte;
      thre_q   <= 1'b0;
      temt_q   <= 1'b0;
    end else if (tx_done) begin
      tx_valid <= 1'b0;
      thre_q   <= 1'b1;
      temt_q   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbr_q <= '0;
      rdy_q <= 1'b0;
      brk_q <= 1'b0;
    end else if (rx_break) begin
      rbr_q <= '0;
      rdy_q <= 1'b1;
      brk_q <= 1'b1;
    end else if (rx_take) begin
      rbr_q <= rx_data;
      rdy_q <= 1'b1;
    end else if (rbr_rd) begin
      rdy_q <= 1'b0;
      brk_q <= 1'b0;
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !thr_wr) |=> (tx_valid && $stable(tx_data))); // R7
  AST_TX_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !thre_q); // R7
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && !rx_break) |=> $stable(rbr_q)); // R8
  AST_BRK_HAS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    brk_q |-> rdy_q); // R9
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && !rx_break && !rx_valid) |=> (!rdy_q && !brk_q)); // R10
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_wr,
  input  logic          tx_done,
  input  logic          ien_wr,
  input  logic          iid_rd,
  input  logic          thre,
  input  logic          rdy,
  input  logic [1:0]    ien,
  output logic [DW-1:0] iid,
  output logic          irq
);
  logic pend_q;

  assign iid = iid_code(rdy && ien[0], pend_q && ien[1]);
  assign irq = (iid != IID_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n)                                pend_q <= 1'b0;
    else if (thr_wr)                           pend_q <= 1'b0;
    else if (tx_done || (ien_wr && thre))      pend_q <= 1'b1;
    else if (iid_rd && (iid == IID_TXE))       pend_q <= 1'b0;
  end

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_rd && iid == IID_TXE && !tx_done && !ien_wr) |=> !pend_q); // R5
  AST_PEND_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_wr && thre && !thr_wr) |=> pend_q); // R6
  AST_RX_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && ien[0]) |-> (irq && iid != IID_TXE)); // R4
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_rd,
  output logic [7:0]    bus_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  input  logic          rx_break,
  output logic          irq
);
  localparam int unsigned IEN_W  = 4;
  localparam int unsigned MCTL_W = 5;

  logic              dlab, ien_wr, thr_wr, rbr_rd, iid_rd;
  logic [DW-1:0]     lctl_q, mst_q, scr_q, rbr_q, lst, iid;
  logic [IEN_W-1:0]  ien_q;
  logic [MCTL_W-1:0] mctl_q;
  logic [DIV_W-1:0]  div_q;
  logic              thre, rdy, tx_done;

  assign thr_wr = bus_wr && (bus_addr == OFS_DATA) && !dlab;
  assign rbr_rd = bus_rd && (bus_addr == OFS_DATA) && !dlab;
  assign iid_rd = bus_rd && (bus_addr == OFS_IID);

  uart_rf_ctl #(.IEN_W(IEN_W), .MCTL_W(MCTL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .dlab(dlab), .ien_wr(ien_wr), .lctl_q(lctl_q), .ien_q(ien_q), .mctl_q(mctl_q),
    .mst_q(mst_q), .scr_q(scr_q), .div_q(div_q)
  );

  uart_rf_line u_line (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_byte(bus_wdata), .rbr_rd(rbr_rd),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .rx_break(rx_break),
    .rbr_q(rbr_q), .lst(lst), .thre(thre), .rdy(rdy), .tx_done(tx_done)
  );

  uart_rf_irq u_irq (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .tx_done(tx_done), .ien_wr(ien_wr),
    .iid_rd(iid_rd), .thre(thre), .rdy(rdy), .ien(ien_q[1:0]), .iid(iid), .irq(irq)
  );

  always_comb begin
    case (bus_addr)
      OFS_DATA: bus_rdata = dlab ? div_q[DW-1:0] : rbr_q;
      OFS_IEN:  bus_rdata = dlab ? div_q[DIV_W-1:DW] : {{(DW-IEN_W){1'b0}}, ien_q};
      OFS_IID:  bus_rdata = iid;
      OFS_LCTL: bus_rdata = lctl_q;
      OFS_MCTL: bus_rdata = {{(DW-MCTL_W){1'b0}}, mctl_q};
      OFS_LST:  bus_rdata = lst;
      OFS_MST:  bus_rdata = mctl_q[4] ? loop_status(mctl_q) : mst_q;
      default:  bus_rdata = scr_q;
    endcase
  end

  AST_DLAB_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && dlab && !tx_valid) |=> !tx_valid); // R2
  AST_LST_CONST_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (lst[7] == 1'b0) && (lst[3:1] == 3'b000)); // R12
endmodule

// File: tb/test_uart_regfile.sv
module test_uart_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0, rx_ready, rx_break = 1'b0;
  logic [7:0] rx_data = '0;
  logic       irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] rv;
  logic       irq_s;

  always #10ns clk = ~clk;

  uart_regfile i_uart_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_break(rx_break), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1ns d = bus_rdata; irq_s = irq;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk);
    rx_data = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [7:0] exp_iid(input logic dr, input logic pend, input logic [3:0] en);
    if (dr && en[0])        return 8'h04;
    else if (pend && en[1]) return 8'h02;
    else                    return 8'h01;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic pend, dr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd5, rv); chk("R1 lsr", rv, 8'h60);
    rd(3'd2, rv); chk("R1 iid", rv, 8'h01);
    chk("R1 irq", {7'b0, irq_s}, 8'h00);
    chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    wr(3'd3, 8'h80);
    rd(3'd0, rv); chk("R1 div lo", rv, 8'h00);
    rd(3'd1, rv); chk("R1 div hi", rv, 8'h00);

    // R2 divisor access
    for (int k = 0; k < 8; k++) begin
      logic [15:0] dv;
      dv = 16'(k * 16'h2F31 + 16'h0107);
      wr(3'd0, dv[7:0]); wr(3'd1, dv[15:8]);
      chk("R2 no tx", {7'b0, tx_valid}, 8'h00);
      rd(3'd0, rv); chk("R2 div lo", rv, dv[7:0]);
      rd(3'd1, rv); chk("R2 div hi", rv, dv[15:8]);
    end
    rd(3'd3, rv); chk("R12 lctl", rv, 8'h80);
    wr(3'd3, 8'h03);
    rd(3'd3, rv); chk("R12 lctl", rv, 8'h03);

    // R3 enable mask sweep; each write rearms pending (R6)
    for (int v = 0; v < 256; v++) begin
      wr(3'd1, 8'(v));
      rd(3'd1, rv); chk("R3 ien mask", rv, 8'(v) & 8'h0F);
    end
    pend = 1'b1;

    // R4/R5/R6 identification sweep, buffer empty then full
    for (int pass = 0; pass < 2; pass++) begin
      dr = (pass == 1);
      if (dr) begin
        push_rx(8'h3C);
        chk("R8 rx_ready low", {7'b0, rx_ready}, 8'h00);
      end
      for (int v = 0; v < 16; v++) begin
        logic [7:0] e;
        wr(3'd1, 8'(v)); pend = 1'b1;          // R6
        for (int r = 0; r < 2; r++) begin
          e = exp_iid(dr, pend, 4'(v));
          rd(3'd2, rv); chk("R4 iid", rv, e);
          chk("R4 irq", {7'b0, irq_s}, {7'b0, e != 8'h01});
          if (e == 8'h02) pend = 1'b0;          // R5
        end
      end
      if (dr) begin
        rd(3'd0, rv); chk("R10 rbr", rv, 8'h3C);
      end
    end

    // R7 transmit path with held-off sink
    wr(3'd1, 8'h02); pend = 1'b1;
    wr(3'd0, 8'h5A);
    chk("R7 tx_valid", {7'b0, tx_valid}, 8'h01);
    chk("R7 tx_data", tx_data, 8'h5A);
    rd(3'd5, rv); chk("R7 lsr busy", rv, 8'h00);
    rd(3'd2, rv); chk("R7 pend cleared", rv, 8'h01);
    repeat (3) @(negedge clk);
    chk("R7 tx_data held", tx_data, 8'h5A);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R7 accepted", {7'b0, tx_valid}, 8'h00);
    rd(3'd5, rv); chk("R7 lsr empty", rv, 8'h60);
    rd(3'd2, rv); chk("R7 pend set", rv, 8'h02);
    chk("R4 irq tx", {7'b0, irq_s}, 8'h01);

    // R8/R9/R10 receive path
    wr(3'd1, 8'h01);
    push_rx(8'hA7);
    rd(3'd5, rv); chk("R8 lsr rdy", rv, 8'h61);
    push_rx(8'h11);
    rd(3'd0, rv); chk("R8 second byte ignored", rv, 8'hA7);
    rd(3'd5, rv); chk("R10 lsr cleared", rv, 8'h60);
    chk("R8 rx_ready high", {7'b0, rx_ready}, 8'h01);
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
    rd(3'd5, rv); chk("R9 lsr break", rv, 8'h71);
    rd(3'd2, rv); chk("R4 rx iid", rv, 8'h04);
    rd(3'd0, rv); chk("R9 rbr zero", rv, 8'h00);
    rd(3'd5, rv); chk("R10 lsr after break", rv, 8'h60);

    // R12 plain registers and ignored writes
    wr(3'd6, 8'hA5); wr(3'd7, 8'h3E);
    rd(3'd7, rv); chk("R12 scratch", rv, 8'h3E);
    wr(3'd5, 8'hFF); rd(3'd5, rv); chk("R12 lsr write ignored", rv, 8'h60);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'hFF); rd(3'd2, rv); chk("R12 iid write ignored", rv, 8'h01);

    // R11 / R3 modem control sweep
    for (int v = 0; v < 32; v++) begin
      logic [7:0] e;
      wr(3'd4, 8'(v) | 8'hE0);
      rd(3'd4, rv); chk("R3 mctl mask", rv, 8'(v));
      e = v[4] ? {v[3], v[2], v[0], v[1], 4'b0000} : 8'hA5;
      rd(3'd6, rv); chk("R11 modem status", rv, e);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule